// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block sits between one DMA client and memory and turns 32-bit device virtual addresses into 40-bit physical addresses. On a miss it reads three words through a 32-bit read port, one after another: a pointer word whose address comes from the base register, then a directory entry, then a page entry. Pages are 4 KiB. The virtual address is split into a 10-bit directory index in bits 31:22, a 10-bit page index in bits 21:12 and a 12-bit offset in bits 11:0. The block keeps the most recent translation in a single-entry buffer, so repeated accesses to one page are answered without any memory traffic.

Software controls the block through a small word-indexed register port. Its registers hold the enable bit, the pointer-word address, a flush bit, a three-bit fault cause and the address of the most recent fault. An invalid entry, or a write to a page that is not writable, gives the client an error response and raises an interrupt line that stays high until software clears the cause. While translation is disabled, addresses pass straight through.

Top module: `iommu_walker`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid, mem_req and irq are 0, and the control and status registers read 0.
- R2: While control bit 0 is 0, an accepted request is answered in the next cycle with rsp_paddr equal to the zero-extended virtual address and rsp_err 0, and no memory read is issued.
- R3: On a buffer miss the block reads, in this order: the base register value; ({pointer[31:10], 10'b0}) + 4 * vaddr[31:22]; ({dirent[31:6], 6'b0}) + 4 * vaddr[21:12]. Only one read is outstanding at a time.
- R4: A valid page entry (bit 0 set) gives rsp_paddr = {pte[11:4], pte[31:12], vaddr[11:0]}.
- R5: A request whose virtual page matches the buffered translation is answered in the cycle after acceptance and issues no memory read.
- R6: A directory entry with bit 0 clear ends the walk after two reads with an error response and sets status bit 0.
- R7: A page entry with bit 0 clear gives an error response and sets status bit 1.
- R8: A write request to a page whose entry has bit 2 clear gives an error response and sets status bit 2. A read of the same page succeeds.
- R9: An error response carries rsp_paddr 0. irq is 1 in the same cycle, and the fault-address register holds the faulting virtual address.
- R10: Any write to the status register clears it and drops irq. A fault in the same cycle takes priority and is still recorded.
- R11: The buffered translation is discarded when the flush register is written with bit 0 set, when the base register is written, and when control is written with bit 0 clear. The next request then walks again.
- R12: Register indices on cfg_addr: 0 control (bit 0 enable), 1 base, 2 flush (bit 0, reads 0), 3 status (bits 2:0), 4 fault address. cfg_rdata shows the register selected on the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data |
| req_valid | input | 1 | Client request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Request is a write |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_paddr | output | 40 | Physical address, 0 on error |
| rsp_err | output | 1 | Translation fault |
| mem_req | output | 1 | Table read strobe |
| mem_addr | output | 32 | Table read address |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Read data |
| irq | output | 1 | Fault interrupt, high while any status bit is set |

## Verification
The bound checker watches, on every cycle, that an error response carries a zero address together with a raised interrupt, that a response only follows an accepted request or a returned read, that reads are never issued back to back, and that pass-through responses echo the virtual address without touching memory. Only the bench's scenarios can show the read order and computed table addresses of a walk, the packing of the upper physical bits, and the distinction between a hit and a miss (one-cycle latency and zero reads versus three reads). The same holds for each invalidation trigger and for the contents of the status and fault-address registers after each kind of fault.

// File: rtl/iommu_walker_pkg.sv
package iommu_walker_pkg;
  localparam int VA_W  = 32;
  localparam int PA_W  = 40;
  localparam int OFF_W = 12;
  localparam int IX_W  = 10;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int RIX_W = 3;
  localparam int NCAUSE = 3;

  localparam logic [RIX_W-1:0] RG_CTRL  = 3'd0;
  localparam logic [RIX_W-1:0] RG_BASE  = 3'd1;
  localparam logic [RIX_W-1:0] RG_FLUSH = 3'd2;
  localparam logic [RIX_W-1:0] RG_STAT  = 3'd3;
  localparam logic [RIX_W-1:0] RG_FADDR = 3'd4;

  localparam int FB_DIR = 0;
  localparam int FB_PTE = 1;
  localparam int FB_WR  = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_PTR, ST_DIR, ST_PTE} walk_st_t;
endpackage

// File: rtl/iw_regs.sv
module iw_regs
  import iommu_walker_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [RIX_W-1:0]  cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [NCAUSE-1:0] fault_set,
  input  logic [VA_W-1:0]   fault_va,
  output logic              ctl_en,
  output logic [31:0]       tbl_base,
  output logic              tlb_inval,
  output logic              irq
);
  logic [NCAUSE-1:0] stat_q, stat_d;
  logic [VA_W-1:0]   faddr_q;
  logic              stat_wr;

  assign stat_wr   = cfg_we && (cfg_addr == RG_STAT);
  assign stat_d    = (stat_wr ? '0 : stat_q) | fault_set;
  assign tlb_inval = cfg_we && (((cfg_addr == RG_FLUSH) && cfg_wdata[0]) ||
                                (cfg_addr == RG_BASE) ||
                                ((cfg_addr == RG_CTRL) && !cfg_wdata[0]));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_en    <= 1'b0;
      tbl_base  <= '0;
      stat_q    <= '0;
      faddr_q   <= '0;
      irq       <= 1'b0;
      cfg_rdata <= '0;
    end else begin
      if (cfg_we && (cfg_addr == RG_CTRL)) ctl_en <= cfg_wdata[0];
      if (cfg_we && (cfg_addr == RG_BASE)) tbl_base <= cfg_wdata;
      stat_q <= stat_d;
      irq    <= |stat_d;
      if (|fault_set) faddr_q <= fault_va;
      case (cfg_addr)
        RG_CTRL:  cfg_rdata <= {31'b0, ctl_en};
        RG_BASE:  cfg_rdata <= tbl_base;
        RG_STAT:  cfg_rdata <= {{(32-NCAUSE){1'b0}}, stat_q};
        RG_FADDR: cfg_rdata <= faddr_q;
        default:  cfg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/iw_tlb.sv
module iw_tlb #(
  parameter int VPN_W = 20,
  parameter int PPN_W = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inval,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             hit,
  output logic [PPN_W-1:0] hit_ppn,
  output logic             hit_wr,
  input  logic             fill,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_wr
);
  logic             vld_q;
  logic [VPN_W-1:0] vpn_q;

  always_ff @(posedge clk) begin
    if (rst || inval) begin
      vld_q <= 1'b0;
    end else if (fill) begin
      vld_q   <= 1'b1;
      vpn_q   <= fill_vpn;
      hit_ppn <= fill_ppn;
      hit_wr  <= fill_wr;
    end
  end

  assign hit = vld_q && (vpn_q == lk_vpn);
endmodule

// File: rtl/iw_walk.sv
module iw_walk
  import iommu_walker_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_err,
  output logic              mem_req,
  output logic [31:0]       mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  input  logic              ctl_en,
  input  logic [31:0]       tbl_base,
  output logic [VPN_W-1:0]  lk_vpn,
  input  logic              hit,
  input  logic [PPN_W-1:0]  hit_ppn,
  input  logic              hit_wr,
  output logic              fill,
  output logic [VPN_W-1:0]  fill_vpn,
  output logic [PPN_W-1:0]  fill_ppn,
  output logic              fill_wr,
  output logic [NCAUSE-1:0] fault_set,
  output logic [VA_W-1:0]   fault_va
);
  localparam int PAD_W = 32 - IX_W - 2;

  walk_st_t        st_q;
  logic [VA_W-1:0] va_q;
  logic            wr_q;
  logic            unused_bits;

  assign unused_bits = ^{mem_rdata[3], mem_rdata[1]};
  assign req_ready   = (st_q == ST_IDLE);
  assign lk_vpn      = req_vaddr[VA_W-1:OFF_W];
  assign fill        = (st_q == ST_PTE) && mem_rvalid && mem_rdata[0];
  assign fill_vpn    = va_q[VA_W-1:OFF_W];
  assign fill_ppn    = {mem_rdata[11:4], mem_rdata[31:12]};
  assign fill_wr     = mem_rdata[2];
  assign fault_va    = (st_q == ST_IDLE) ? req_vaddr : va_q;

  always_comb begin
    fault_set = '0;
    case (st_q)
      ST_IDLE: if (req_valid && ctl_en && hit && req_write && !hit_wr) fault_set[FB_WR] = 1'b1;
      ST_DIR:  if (mem_rvalid && !mem_rdata[0]) fault_set[FB_DIR] = 1'b1;
      ST_PTE:  if (mem_rvalid) begin
                 if (!mem_rdata[0])                    fault_set[FB_PTE] = 1'b1;
                 else if (wr_q && !mem_rdata[2])       fault_set[FB_WR]  = 1'b1;
               end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_paddr <= '0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      va_q      <= '0;
      wr_q      <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      mem_req   <= 1'b0;
      if (|fault_set) begin
        rsp_valid <= 1'b1;
        rsp_err   <= 1'b1;
        rsp_paddr <= '0;
      end
      case (st_q)
        ST_IDLE: if (req_valid) begin
          va_q <= req_vaddr;
          wr_q <= req_write;
          if (!ctl_en) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b0;
            rsp_paddr <= {{(PA_W-VA_W){1'b0}}, req_vaddr};
          end else if (hit) begin
            if (fault_set == '0) begin
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b0;
              rsp_paddr <= {hit_ppn, req_vaddr[OFF_W-1:0]};
            end
          end else begin
            mem_req  <= 1'b1;
            mem_addr <= tbl_base;
            st_q     <= ST_PTR;
          end
        end
        ST_PTR: if (mem_rvalid) begin
          mem_req  <= 1'b1;
          mem_addr <= {mem_rdata[31:10], 10'b0} +
                      {{PAD_W{1'b0}}, va_q[VA_W-1 -: IX_W], 2'b00};
          st_q     <= ST_DIR;
        end
        ST_DIR: if (mem_rvalid) begin
          if (mem_rdata[0]) begin
            mem_req  <= 1'b1;
            mem_addr <= {mem_rdata[31:6], 6'b0} +
                        {{PAD_W{1'b0}}, va_q[OFF_W+IX_W-1:OFF_W], 2'b00};
            st_q     <= ST_PTE;
          end else begin
            st_q <= ST_IDLE;
          end
        end
        ST_PTE: if (mem_rvalid) begin
          st_q <= ST_IDLE;
          if (fault_set == '0) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b0;
            rsp_paddr <= {fill_ppn, va_q[OFF_W-1:0]};
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/iommu_walker.sv
module iommu_walker
  import iommu_walker_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [RIX_W-1:0] cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_err,
  output logic             mem_req,
  output logic [31:0]      mem_addr,
  input  logic             mem_rvalid,
  input  logic [31:0]      mem_rdata,
  output logic             irq
);
  logic              ctl_en;
  logic [31:0]       tbl_base;
  logic              tlb_inval;
  logic [NCAUSE-1:0] fault_set;
  logic [VA_W-1:0]   fault_va;
  logic [VPN_W-1:0]  lk_vpn, fill_vpn;
  logic [PPN_W-1:0]  hit_ppn, fill_ppn;
  logic              hit, hit_wr, fill, fill_wr;

  iw_regs u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fault_set(fault_set),
    .fault_va(fault_va), .ctl_en(ctl_en), .tbl_base(tbl_base),
    .tlb_inval(tlb_inval), .irq(irq)
  );

  iw_tlb #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_tlb (
    .clk(clk), .rst(rst), .inval(tlb_inval), .lk_vpn(lk_vpn), .hit(hit),
    .hit_ppn(hit_ppn), .hit_wr(hit_wr), .fill(fill), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .fill_wr(fill_wr)
  );

  iw_walk u_walk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_err(rsp_err), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .ctl_en(ctl_en), .tbl_base(tbl_base), .lk_vpn(lk_vpn), .hit(hit),
    .hit_ppn(hit_ppn), .hit_wr(hit_wr), .fill(fill), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .fill_wr(fill_wr), .fault_set(fault_set),
    .fault_va(fault_va)
  );
endmodule

// File: rtl/iommu_walker_chk.sv
module iommu_walker_chk
  import iommu_walker_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_vaddr,
  input logic            rsp_valid,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            rsp_err,
  input logic            mem_req,
  input logic            mem_rvalid,
  input logic            irq,
  input logic            ctl_en
);
  AST_ERR_ZERO_IRQ: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_err |-> irq && (rsp_paddr == '0)); // R9

  AST_BYPASS_ECHO: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && $past(req_valid && req_ready && !ctl_en)
      |-> !rsp_err && (rsp_paddr == {{(PA_W-VA_W){1'b0}}, $past(req_vaddr)})); // R2

  AST_BYPASS_NO_READ: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && !ctl_en |=> !mem_req); // R2

  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req); // R3

  AST_RSP_CAUSED: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && req_ready) || $past(mem_rvalid)); // R5
endmodule

bind iommu_walker iommu_walker_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
  .rsp_err(rsp_err), .mem_req(mem_req), .mem_rvalid(mem_rvalid),
  .irq(irq), .ctl_en(ctl_en)
);

// File: tb/sim_iommu_walker.sv
module sim_iommu_walker;
  localparam logic [31:0] PTR_A = 32'h0000_8000;
  localparam logic [31:0] DIR_B = 32'h0010_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic [39:0] rsp_paddr;
  logic        rsp_err;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        irq;

  int unsigned vectors = 0;
  int unsigned fails = 0;
  int unsigned cyc = 0;
  int unsigned rd_cnt = 0;
  logic [31:0] rd_log [$];
  logic [31:0] mem [int unsigned];
  int          pend = 0;
  logic [31:0] pend_a;

  bit          tv = 1'b0;
  logic [19:0] tvpn;
  logic [9:0]  dlist [5];

  always #5 clk = ~clk;

  iommu_walker u0 (.*);

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rvalid <= 1'b0;
    if (pend == 1) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= rd(pend_a);
    end
    if (pend > 0) pend <= pend - 1;
    if (mem_req) begin
      pend_a <= mem_addr;
      pend   <= 1 + int'($urandom % 3);
      rd_cnt <= rd_cnt + 1;
      rd_log.push_back(mem_addr);
    end
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if ((a == 3'd2 && d[0]) || a == 3'd1 || (a == 3'd0 && !d[0])) tv = 1'b0;
  endtask

  task automatic cfg_rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    v = cfg_rdata;
  endtask

  task automatic do_req(input logic [31:0] va, input bit wr,
                        output logic [39:0] pa, output bit err, output int lat, output int nrd);
    int unsigned r0;
    @(negedge clk);
    r0 = rd_cnt;
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    pa = rsp_paddr; err = rsp_err;
    nrd = int'(rd_cnt - r0);
  endtask

  // expected walk from the table contents; cause bit 0 dir, 1 page, 2 write
  task automatic model(input logic [31:0] va, input bit wr, output logic [2:0] cause,
                       output logic [39:0] pa, output bit pte_ok, output int nrd);
    logic [31:0] p, d, e;
    cause = 3'b0; pa = '0; pte_ok = 1'b0;
    p = rd(PTR_A);
    d = rd((p & 32'hFFFF_FC00) + {20'b0, va[31:22], 2'b0});
    nrd = 2;
    if (!d[0]) begin cause = 3'b001; return; end
    nrd = 3;
    e = rd((d & 32'hFFFF_FFC0) + {20'b0, va[21:12], 2'b0});
    if (!e[0]) begin cause = 3'b010; return; end
    pte_ok = 1'b1;
    if (wr && !e[2]) begin cause = 3'b100; return; end
    pa = {e[11:4], e[31:12], va[11:0]};
  endtask

  initial begin
    logic [31:0] v;
    logic [39:0] pa, epa;
    logic [2:0]  cause;
    bit          err, pok;
    int          lat, nrd, enrd;
    logic [31:0] va;
    void'($urandom(32'd1234));

    // tables: dir index 5, 0, 1023, 300 mapped; pte garbage in dirent bits 5:1
    mem[PTR_A] = DIR_B;
    dlist[0] = 10'd5; dlist[1] = 10'd0; dlist[2] = 10'd1023; dlist[3] = 10'd300; dlist[4] = 10'd7;
    for (int k = 0; k < 4; k++) begin
      logic [31:0] ptb;
      ptb = 32'h0020_0000 + 32'(k) * 32'h1000;
      mem[DIR_B + {20'b0, dlist[k], 2'b0}] = ptb | 32'h2F;
      for (int p = 0; p < 17; p++) begin
        logic [31:0] e;
        int pi;
        pi = (p == 16) ? 1023 : p;
        e = $urandom;
        e[0] = ($urandom % 8) != 0;
        mem[ptb + 32'(pi) * 4] = e;
      end
    end
    mem[32'h0020_0000 + 3 * 4] = 32'hABCD_E0F5;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready", 64'(req_ready), 64'd1);
    chk(!rsp_valid && !mem_req && !irq, "R1 outputs idle", {rsp_valid, mem_req, irq}, 64'd0);
    cfg_rd(3'd0, v); chk(v == 0, "R1 control", 64'(v), 64'd0);
    cfg_rd(3'd3, v); chk(v == 0, "R1 status", 64'(v), 64'd0);

    do_req(32'hDEAD_BEEF, 1'b1, pa, err, lat, nrd);
    chk(pa == 40'h00_DEAD_BEEF && !err, "R2 bypass addr", 64'(pa), 64'h00DEADBEEF);
    chk(lat == 1 && nrd == 0, "R2 bypass timing/reads", {32'(lat), 32'(nrd)}, {32'd1, 32'd0});

    cfg_wr(3'd1, PTR_A);
    cfg_wr(3'd0, 32'h1);
    cfg_rd(3'd1, v); chk(v == PTR_A, "R12 base readback", 64'(v), 64'(PTR_A));
    cfg_rd(3'd0, v); chk(v == 1, "R12 control readback", 64'(v), 64'd1);
    cfg_rd(3'd2, v); chk(v == 0, "R12 flush reads 0", 64'(v), 64'd0);

    va = {10'd5, 10'd3, 12'hABC};
    rd_log.delete();
    do_req(va, 1'b1, pa, err, lat, nrd);
    chk(nrd == 3, "R3 read count", 64'(nrd), 64'd3);
    chk(rd_log.size() == 3 && rd_log[0] == PTR_A && rd_log[1] == DIR_B + 32'd20 &&
        rd_log[2] == 32'h0020_000C, "R3 read order",
        (rd_log.size() == 3) ? {rd_log[1], rd_log[2]} : 64'(rd_log.size()), {DIR_B + 32'd20, 32'h0020_000C});
    chk(pa == 40'h0F_ABCD_EABC && !err, "R4 packed address", 64'(pa), 64'h0FABCDEABC);
    tv = 1'b1; tvpn = va[31:12];

    mem[32'h0020_0000 + 3 * 4] = 32'h1234_5071;
    do_req({10'd5, 10'd3, 12'h001}, 1'b0, pa, err, lat, nrd);
    chk(lat == 1 && nrd == 0 && pa == 40'h0F_ABCD_E001, "R5 hit keeps old entry", 64'(pa), 64'h0FABCDE001);

    cfg_wr(3'd2, 32'h1);
    do_req(va, 1'b0, pa, err, lat, nrd);
    chk(nrd == 3 && pa == 40'h07_1234_5ABC, "R11 flush forces walk", 64'(pa), 64'h0712345ABC);

    do_req(va, 1'b1, pa, err, lat, nrd);
    chk(err && lat == 1, "R8 write to read-only", {32'(err), 32'(lat)}, {32'd1, 32'd1});
    chk(pa == 0 && irq, "R9 zero addr and irq", {24'b0, irq, pa[38:0]}, 64'h80_0000_0000);
    cfg_rd(3'd3, v); chk(v == 32'h4, "R8 status bit 2", 64'(v), 64'h4);
    cfg_rd(3'd4, v); chk(v == va, "R9 fault address", 64'(v), 64'(va));
    do_req(va, 1'b0, pa, err, lat, nrd);
    chk(!err && pa == 40'h07_1234_5ABC, "R8 read same page ok", 64'(pa), 64'h0712345ABC);

    cfg_wr(3'd3, 32'h0);
    @(negedge clk);
    chk(!irq, "R10 irq cleared", 64'(irq), 64'd0);
    cfg_rd(3'd3, v); chk(v == 0, "R10 status cleared", 64'(v), 64'd0);

    va = {10'd7, 10'd1, 12'h010};
    do_req(va, 1'b0, pa, err, lat, nrd);
    chk(err && nrd == 2, "R6 invalid dir", {32'(err), 32'(nrd)}, {32'd1, 32'd2});
    cfg_rd(3'd3, v); chk(v == 32'h1, "R6 status bit 0", 64'(v), 64'h1);
    cfg_wr(3'd3, 32'h0);

    va = {10'd5, 10'd200, 12'h000};
    do_req(va, 1'b0, pa, err, lat, nrd);
    chk(err && nrd == 3, "R7 invalid page", {32'(err), 32'(nrd)}, {32'd1, 32'd3});
    cfg_rd(3'd3, v); chk(v == 32'h2, "R7 status bit 1", 64'(v), 64'h2);
    cfg_wr(3'd3, 32'h0);

    va = {10'd5, 10'd3, 12'h000};
    do_req(va, 1'b0, pa, err, lat, nrd);
    cfg_wr(3'd1, PTR_A);
    do_req(va, 1'b0, pa, err, lat, nrd);
    chk(nrd == 3, "R11 base write invalidates", 64'(nrd), 64'd3);
    cfg_wr(3'd0, 32'h0);
    cfg_wr(3'd0, 32'h1);
    do_req(va, 1'b0, pa, err, lat, nrd);
    chk(nrd == 3, "R11 disable invalidates", 64'(nrd), 64'd3);
    tv = 1'b1; tvpn = va[31:12];

    for (int i = 0; i < 400; i++) begin
      bit wr, hit;
      if (($urandom % 3) == 0 && tv) va = {tvpn, 12'($urandom)};
      else begin
        logic [9:0] pi;
        pi = (($urandom % 10) == 0) ? 10'd1023 : 10'($urandom % 18);
        va = {dlist[$urandom % 5], pi, (($urandom % 8) == 0) ? 12'hFFF : 12'($urandom)};
      end
      wr = $urandom % 2;
      hit = tv && (tvpn == va[31:12]);
      model(va, wr, cause, epa, pok, enrd);
      do_req(va, wr, pa, err, lat, nrd);
      chk(err == (cause != 0) && pa == epa, "R4 random translate", 64'(pa), 64'(epa));
      if (hit) chk(lat == 1 && nrd == 0, "R5 random hit", {32'(lat), 32'(nrd)}, {32'd1, 32'd0});
      else     chk(nrd == enrd, "R3 random walk reads", 64'(nrd), 64'(enrd));
      if (pok) begin tv = 1'b1; tvpn = va[31:12]; end
      if (cause != 0) begin
        cfg_rd(3'd3, v); chk(v[2:0] == cause, "R9 random cause", 64'(v), 64'(cause));
        cfg_wr(3'd3, 32'h0);
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule